// File: doc/BRIEF.md
# Multicore Boot Release Spin Table

This block keeps one 32-byte boot-release entry for every secondary core of a multicore cluster. Each entry carries a 64-bit launch address, a 64-bit argument and a 32-bit processor identifier, all in big-endian byte order. Firmware running on the primary core parks each secondary core by leaving bit 0 of its launch address at 1. It releases a core by rewriting that address so that bit 0 becomes 0.

Once a release takes effect, the block raises a one-cycle start pulse on that core's line. On the same cycle it presents the core's start program counter and argument, plus the base and size of a 64 MiB translation window that the core's boot code maps before it jumps. The start program counter is the launch address taken modulo the window size, and the window base is the launch address with those low bits cleared.

Register access goes through a single-cycle request port with byte addresses and 1-, 2- or 4-byte transfers. A request is taken whenever `req_valid` is high. There is no back-pressure in either direction. No ready pin exists, and the single response appears exactly one cycle later and cannot be stalled.

Top module: `spin_table`

## Requirements
- R1: After reset, every entry k reads back launch address 1, argument k and identifier k, and its reserved bytes read 0. No start pulse and no response are active.
- R2: A read of 1, 2 or 4 bytes returns the bytes from the addressed offset. The lowest address goes in the most significant position, the value is right-aligned in `rsp_rdata`, and it arrives one cycle after the request.
- R3: A write of 1, 2 or 4 bytes changes only the addressed bytes, in the same big-endian placement as a read. Bytes beside them keep their values.
- R4: Writes to entry 0 (the primary core) or to any entry with index `NCORES` or above are discarded without an error, so a later read returns the old contents.
- R5: A write to an entry whose launch address bit 0 goes from 1 to 0 raises `go_pulse[k]` for exactly one cycle. This happens in the cycle in which the write's response is valid.
- R6: With the pulse, `go_pc` equals the launch address with bits 63..26 cleared, `go_base` equals the launch address with bits 25..0 cleared, and `go_arg` equals the argument field. `go_size` is always 64 MiB (0x400_0000).
- R7: A release rewrites the entry's identifier bytes (offsets 20..23) with the core's own index, replacing any value written earlier.
- R8: A core is not released again until its launch address bit 0 has been written back to 1 and then to 0. Writes that leave bit 0 at 0 raise no pulse.
- R9: A transfer length other than 1, 2 or 4 sets `rsp_err`, returns zero data and changes no storage.
- R10: An access whose bytes would extend past the end of the 32-entry region, or past the end of its own 32-byte entry, sets `rsp_err` and changes no storage.
- R11: Releases of different cores by writes in consecutive cycles each produce their own pulse. None is lost.
- R12: Every accepted request produces exactly one response one cycle later, and idle cycles produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle (always accepted) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BUS_AW | Byte address inside the table |
| req_len | input | 3 | Transfer length in bytes |
| req_wdata | input | 32 | Write value, right-aligned |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read value, right-aligned; 0 for writes and errors |
| rsp_err | output | 1 | Bad length or out-of-range access |
| go_pulse | output | NCORES | One-cycle start strobe per core |
| go_pc | output | 64 | Start program counter of the released core |
| go_arg | output | 64 | Argument of the released core |
| go_base | output | 64 | Translation window base |
| go_size | output | 64 | Translation window size |

## Verification
The assertions assume that `req_valid`, `req_write`, `req_len` and `req_addr` are known and settled at every rising edge, and that the requester never expects to be stalled. The pulse and window properties also rely on releases happening only through writes. The bench drives all inputs on falling edges, one request per cycle or idle, with known values only. It covers back-to-back requests as well as idle gaps, so the one-response-per-request rule is exercised in both directions.

// File: rtl/spin_pkg.sv
package spin_pkg;
  localparam int ENTRY_BYTES = 32;
  localparam int PID_OFF     = 20;

  // value of byte b of entry s after reset
  function automatic logic [7:0] reset_byte(input int s, input int b);
    logic [63:0] v;
    v = 64'(s);
    if (b == 7)                 return 8'h01;
    else if (b >= 8 && b < 16)  return v[8*(15-b) +: 8];
    else if (b >= 20 && b < 24) return v[8*(23-b) +: 8];
    else                        return 8'h00;
  endfunction

  // byte k (0 = lowest address) of a right-aligned big-endian value
  function automatic logic [7:0] wbyte(input logic [31:0] d, input logic [2:0] len, input int k);
    logic [31:0] t;
    int sh;
    sh = 8 * (int'(len) - 1 - k);
    if (sh < 0) sh = 0;
    t = d >> sh;
    return t[7:0];
  endfunction
endpackage

// File: rtl/spin_decode.sv
module spin_decode import spin_pkg::*; #(
  parameter int BUS_AW = 12,
  parameter int SLOTS  = 32,
  localparam int OFF_W  = $clog2(ENTRY_BYTES),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int TOTAL  = SLOTS * ENTRY_BYTES
) (
  input  logic [BUS_AW-1:0] addr,
  input  logic [2:0]        len,
  output logic              acc_err,
  output logic [SLOT_W-1:0] slot,
  output logic [OFF_W-1:0]  off
);
  logic             len_ok;
  logic [BUS_AW:0]  end_a;
  logic [OFF_W:0]   end_o;

  always_comb begin
    off    = addr[OFF_W-1:0];
    slot   = addr[OFF_W +: SLOT_W];
    len_ok = (len == 3'd1) || (len == 3'd2) || (len == 3'd4);
    end_a  = {1'b0, addr} + (BUS_AW+1)'(len);
    end_o  = {1'b0, off} + (OFF_W+1)'(len);
    acc_err = !len_ok || (end_a > (BUS_AW+1)'(TOTAL)) || (end_o > (OFF_W+1)'(ENTRY_BYTES));
  end
endmodule

// File: rtl/spin_regfile.sv
module spin_regfile import spin_pkg::*; #(
  parameter int SLOTS = 32,
  localparam int OFF_W  = $clog2(ENTRY_BYTES),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int TOTAL  = SLOTS * ENTRY_BYTES,
  localparam int MEM_AW = SLOT_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              pid_we,
  input  logic [MEM_AW-1:0] acc_addr,
  input  logic [SLOT_W-1:0] slot,
  input  logic [OFF_W-1:0]  off,
  input  logic [2:0]        len,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_data,
  output logic              cur_bit0,
  output logic [63:0]       new_addr,
  output logic [63:0]       new_arg
);
  logic [7:0]        mem [TOTAL];
  logic [MEM_AW-1:0] base;
  logic [127:0]      fld;
  logic [31:0]       pid;

  assign base = {slot, OFF_W'(0)};
  assign pid  = 32'(slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++)
        for (int b = 0; b < ENTRY_BYTES; b++)
          mem[s*ENTRY_BYTES + b] <= reset_byte(s, b);
    end else begin
      if (we)
        for (int k = 0; k < 4; k++)
          if (3'(k) < len) mem[acc_addr + MEM_AW'(k)] <= wbyte(wdata, len, k);
      if (pid_we)
        for (int k = 0; k < 4; k++)
          mem[base + MEM_AW'(PID_OFF + k)] <= pid[8*(3-k) +: 8];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < 4; k++)
      if (3'(k) < len) rd_data = {rd_data[23:0], mem[acc_addr + MEM_AW'(k)]};
  end

  // launch address and argument as they stand after this cycle's write
  always_comb begin
    logic [7:0] b;
    fld = '0;
    for (int j = 0; j < 16; j++) begin
      b = mem[base + MEM_AW'(j)];
      if (we && j >= int'(off) && j < int'(off) + int'(len))
        b = wbyte(wdata, len, j - int'(off));
      fld = {fld[119:0], b};
    end
  end

  assign cur_bit0 = mem[base + MEM_AW'(7)][0];
  assign new_addr = fld[127:64];
  assign new_arg  = fld[63:0];
endmodule

// File: rtl/spin_release.sv
module spin_release #(
  parameter int NCORES   = 8,
  parameter int SLOT_W   = 5,
  parameter int WIN_BITS = 26,
  localparam logic [63:0] WIN_MASK = (64'(1) << WIN_BITS) - 64'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [SLOT_W-1:0] slot,
  input  logic [63:0]       new_addr,
  input  logic [63:0]       new_arg,
  output logic [NCORES-1:0] go_pulse,
  output logic [63:0]       go_pc,
  output logic [63:0]       go_arg,
  output logic [63:0]       go_base,
  output logic [63:0]       go_size
);
  for (genvar c = 0; c < NCORES; c++) begin : g_core
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) go_pulse[c] <= 1'b0;
      else        go_pulse[c] <= fire && (slot == SLOT_W'(c));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_pc   <= '0;
      go_arg  <= '0;
      go_base <= '0;
    end else if (fire) begin
      go_pc   <= new_addr & WIN_MASK;
      go_base <= new_addr & ~WIN_MASK;
      go_arg  <= new_arg;
    end
  end

  assign go_size = WIN_MASK + 64'(1);
endmodule

// File: rtl/spin_table.sv
module spin_table import spin_pkg::*; #(
  parameter int BUS_AW   = 12,
  parameter int SLOTS    = 32,
  parameter int NCORES   = 8,
  parameter int WIN_BITS = 26,
  localparam int OFF_W  = $clog2(ENTRY_BYTES),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int MEM_AW = SLOT_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BUS_AW-1:0] req_addr,
  input  logic [2:0]        req_len,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [NCORES-1:0] go_pulse,
  output logic [63:0]       go_pc,
  output logic [63:0]       go_arg,
  output logic [63:0]       go_base,
  output logic [63:0]       go_size
);
  logic              acc_err, we, fire, cur_bit0;
  logic [SLOT_W-1:0] slot;
  logic [OFF_W-1:0]  off;
  logic [31:0]       rd_data;
  logic [63:0]       new_addr, new_arg;

  spin_decode #(.BUS_AW(BUS_AW), .SLOTS(SLOTS)) u_dec (
    .addr(req_addr), .len(req_len), .acc_err(acc_err), .slot(slot), .off(off)
  );

  assign we   = req_valid && req_write && !acc_err && (slot != '0) && (int'(slot) < NCORES);
  assign fire = we && cur_bit0 && !new_addr[0];

  spin_regfile #(.SLOTS(SLOTS)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(we), .pid_we(fire),
    .acc_addr(req_addr[MEM_AW-1:0]), .slot(slot), .off(off), .len(req_len),
    .wdata(req_wdata), .rd_data(rd_data), .cur_bit0(cur_bit0),
    .new_addr(new_addr), .new_arg(new_arg)
  );

  spin_release #(.NCORES(NCORES), .SLOT_W(SLOT_W), .WIN_BITS(WIN_BITS)) u_rel (
    .clk(clk), .rst_n(rst_n), .fire(fire), .slot(slot),
    .new_addr(new_addr), .new_arg(new_arg), .go_pulse(go_pulse),
    .go_pc(go_pc), .go_arg(go_arg), .go_base(go_base), .go_size(go_size)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && acc_err;
      rsp_rdata <= (req_valid && !req_write && !acc_err) ? rd_data : '0;
    end
  end
endmodule

// File: rtl/spin_table_chk.sv
module spin_table_chk #(
  parameter int NCORES   = 8,
  parameter int WIN_BITS = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_len,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata,
  input logic [NCORES-1:0] go_pulse,
  input logic [63:0]       go_pc,
  input logic [63:0]       go_base
);
  assert_one_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_bad_len_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_len != 3'd1 && req_len != 3'd2 && req_len != 3'd4) |=> rsp_err);
  assert_err_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 32'd0));
  assert_single_core_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(go_pulse));
  assert_primary_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !go_pulse[0]);
  assert_one_cycle_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go_pulse != '0) |=> ((go_pulse & $past(go_pulse)) == '0));
  assert_pulse_with_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (go_pulse != '0) |-> (rsp_valid && !rsp_err));
  assert_window_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go_pulse != '0) |-> ((go_pc >> WIN_BITS) == 64'd0 && (go_base & ((64'(1) << WIN_BITS) - 64'(1))) == 64'd0));
endmodule

bind spin_table spin_table_chk #(.NCORES(NCORES), .WIN_BITS(WIN_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .go_pulse(go_pulse), .go_pc(go_pc), .go_base(go_base)
);

// File: tb/spin_table_tb.sv
module spin_table_tb;
  localparam int NC = 8, SL = 32, TOT = SL * 32, WIN = 26, AW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0] req_len = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NC-1:0] go_pulse;
  logic [63:0] go_pc, go_arg, go_base, go_size;

  always #2 clk = ~clk;

  spin_table #(.BUS_AW(AW), .SLOTS(SL), .NCORES(NC), .WIN_BITS(WIN)) u_dut (.*);

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic        err;
    logic        rel;
    int          core;
    logic [63:0] pc, base, arg;
  } exp_t;

  exp_t q[$];
  logic [7:0] m [TOT];
  int vectors = 0, fails = 0;
  bit done = 0;

  function automatic logic [63:0] field64(int at);
    logic [63:0] v = '0;
    for (int j = 0; j < 8; j++) v = {v[55:0], m[at + j]};
    return v;
  endfunction

  task automatic acc(input string tag, input bit wr, input int addr, input int len, input logic [31:0] d);
    exp_t e;
    int slot;
    bit old;
    e.tag = tag; e.rd = '0; e.rel = 0; e.core = 0; e.pc = '0; e.base = '0; e.arg = '0;
    e.err = !(len == 1 || len == 2 || len == 4) || (addr + len > TOT) || ((addr % 32) + len > 32);
    if (!e.err && !wr)
      for (int k = 0; k < len; k++) e.rd = {e.rd[23:0], m[addr + k]};
    if (!e.err && wr) begin
      slot = addr / 32;
      if (slot != 0 && slot < NC) begin
        old = m[slot*32 + 7][0];
        for (int k = 0; k < len; k++) m[addr + k] = 8'(d >> (8 * (len - 1 - k)));
        if (old && !m[slot*32 + 7][0]) begin
          e.rel  = 1;
          e.core = slot;
          e.pc   = field64(slot*32) & ((64'(1) << WIN) - 1);
          e.base = field64(slot*32) & ~((64'(1) << WIN) - 1);
          e.arg  = field64(slot*32 + 8);
          for (int k = 0; k < 4; k++) m[slot*32 + 20 + k] = 8'(slot >> (8 * (3 - k)));
        end
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(addr);
    req_len = 3'(len); req_wdata = d;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        exp_t e;
        logic [NC-1:0] ep;
        vectors++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL %s unexpected response: actual rdata=%h expected none", "R12", rsp_rdata);
        end else begin
          e = q.pop_front();
          ep = e.rel ? NC'(1) << e.core : '0;
          if (rsp_rdata !== e.rd || rsp_err !== e.err || go_pulse !== ep ||
              (e.rel && (go_pc !== e.pc || go_base !== e.base || go_arg !== e.arg))) begin
            fails++;
            $display("FAIL %s: actual rd=%h err=%b pulse=%b pc=%h base=%h arg=%h expected rd=%h err=%b pulse=%b pc=%h base=%h arg=%h",
                     e.tag, rsp_rdata, rsp_err, go_pulse, go_pc, go_base, go_arg,
                     e.rd, e.err, ep, e.pc, e.base, e.arg);
          end
        end
      end else if (go_pulse != '0) begin
        vectors++; fails++;
        $display("FAIL R5 pulse without write: actual pulse=%b expected 0", go_pulse);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SL; s++)
      for (int b = 0; b < 32; b++)
        m[s*32 + b] = (b == 7) ? 8'h01 : ((b == 15 || b == 23) ? 8'(s) : 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    if (rsp_valid !== 1'b0 || go_pulse !== '0 || go_size !== 64'h400_0000) begin
      fails++;
      $display("FAIL R1 reset outputs: actual v=%b p=%b size=%h expected 0 0 4000000", rsp_valid, go_pulse, go_size);
    end
    // R1/R2 reset contents and read widths
    acc("R1", 0, 3*32 + 20, 4, 0);
    acc("R1", 0, 3*32 + 12, 4, 0);
    acc("R1", 0, 3*32 + 4, 4, 0);
    acc("R2", 0, 5*32 + 23, 1, 0);
    acc("R2", 0, 6*32 + 6, 2, 0);
    acc("R1", 0, 2*32 + 16, 4, 0);
    idle(2);
    // R3 partial writes
    acc("R3", 1, 2*32 + 0, 4, 32'h0000_0001);
    acc("R3", 1, 2*32 + 4, 4, 32'h0512_3455);
    acc("R3", 0, 2*32 + 4, 4, 0);
    acc("R3", 1, 2*32 + 9, 2, 32'h0000_BEEF);
    acc("R3", 0, 2*32 + 8, 4, 0);
    acc("R3", 0, 2*32 + 10, 2, 0);
    acc("R7", 1, 2*32 + 22, 2, 32'h0000_DEAD);
    acc("R7", 0, 2*32 + 20, 4, 0);
    // R5/R6 release of core 2
    acc("R5", 1, 2*32 + 7, 1, 32'h54);
    acc("R7", 0, 2*32 + 20, 4, 0);
    // R8 no re-release until re-armed
    acc("R8", 1, 2*32 + 7, 1, 32'h50);
    acc("R8", 1, 2*32 + 4, 4, 32'h0800_0010);
    acc("R8", 1, 2*32 + 7, 1, 32'h11);
    acc("R8", 1, 2*32 + 7, 1, 32'h10);
    idle(1);
    // R4 dropped writes
    acc("R4", 1, 7, 1, 0);
    acc("R4", 0, 4, 4, 0);
    acc("R4", 1, 9*32 + 7, 1, 0);
    acc("R4", 0, 9*32 + 4, 4, 0);
    acc("R4", 1, 9*32 + 20, 4, 32'h1234);
    acc("R4", 0, 9*32 + 20, 4, 0);
    // R9 bad lengths
    acc("R9", 0, 3*32, 3, 0);
    acc("R9", 1, 3*32 + 7, 0, 0);
    acc("R9", 1, 3*32 + 4, 7, 0);
    acc("R9", 0, 3*32 + 4, 4, 0);
    // R10 range errors
    acc("R10", 1, 4*32 + 30, 4, 0);
    acc("R10", 0, 1100, 1, 0);
    acc("R10", 1, 1022, 2, 0);
    acc("R10", 0, 1023, 2, 0);
    acc("R10", 0, 4*32 + 4, 4, 0);
    // R11 back-to-back releases
    acc("R11", 1, 3*32 + 4, 4, 32'h0C00_0100);
    acc("R11", 1, 3*32 + 7, 1, 32'h00);
    acc("R11", 1, 4*32 + 7, 1, 32'h00);
    acc("R11", 1, 5*32 + 7, 1, 32'h00);
    acc("R11", 0, 4*32 + 20, 4, 0);
    idle(4);
    wait (q.size() == 0);
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule